// File: doc/BRIEF.md
# Scatter-Gather Descriptor Coalescer

This block turns a stream of scatter-gather entries (local address, byte length, last marker) into block-DMA descriptors and writes each one into a slot of a descriptor ring. A transfer opens with a one-cycle `start` pulse that latches the per-transfer settings: direction, write-response mode, target ID, starting remote address, system-size code and whether an interrupt is wanted at the end. Entries then arrive on a valid/ready port.

Entries that continue exactly where the open descriptor ends are folded into it, as long as its byte total stays within `MAX_BYTES`. Any other entry closes the open descriptor, writes it out and opens a new one in a freshly allocated slot. The slot allocator runs a wrapping write counter over a power-of-two ring and never hands out the last slot, which holds the ring's link descriptor. An entry larger than `MAX_BYTES` aborts the transfer. The allocator then rolls back to its value at `start`, which releases every slot the transfer claimed, and the rest of the transfer's entries are swallowed. A `done` pulse reports the first slot and the number of descriptors.

Top module: `sgc_coalescer`

## Requirements
- R1: An entry whose address equals the open descriptor's running end address is merged into it when the summed count is at most `MAX_BYTES`. Only the count field grows: the slot, the remote address and the local address of the descriptor stay unchanged.
- R2: An entry that is not contiguous, or whose merge would exceed `MAX_BYTES`, causes the open descriptor to be written with its final count and a new descriptor to be opened.
- R3: An entry longer than `MAX_BYTES` aborts the transfer. The open descriptor is not written. Entries are accepted and dropped up to and including the last one. `done` then reports `done_err`=1 and `done_count`=0. The write counter returns to its value at `start`, so the next transfer starts in the same slot.
- R4: The remote address advances by the length of every accepted entry. A new descriptor carries the running remote address from the moment it opens.
- R5: Slot = write counter mod `RING`. When that value is `RING-1`, slot 0 is used and the counter advances by 2 instead of 1. Slot `RING-1` is never written. The counter persists across transfers.
- R6: Word 0 layout: bits 31:29 = 1 (data descriptor), bit 27 = interrupt-on-finish, bits 22:19 = request code, bits 15:0 = target ID, all other bits 0. Bit 27 is set only on the final descriptor, and only when `cfg_irq` was set.
- R7: Word 1 layout: bits 31:30 = remote address bits 1:0, bits 29:26 = system-size code, bits 25:0 = byte count.
- R8: Request code: 0 when `cfg_to_dev`=0 (read). When `cfg_to_dev`=1 the code depends on `cfg_wr_mode`: mode 0 gives 1 (all writes without response), mode 1 gives 2 (all writes with response), and modes 2 and 3 give 3 (only the last write with response).
- R9: Word 2 = {2'b00, remote address bits 31:2}. Word 3 = the local address of the descriptor's first entry.
- R10: The final descriptor is written one cycle after the last entry is accepted. `done` pulses in the same cycle as that write, with `done_first` = slot of the first descriptor and `done_count` = number written. `ent_ready` is low while idle and in that final cycle.
- R11: After reset, `wr_en`, `done` and `ent_ready` are 0, and the first slot allocated is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens a transfer when idle, latching the cfg_* inputs |
| cfg_to_dev | input | 1 | 1 = memory-to-device write, 0 = device-to-memory read |
| cfg_wr_mode | input | 2 | Write-response mode |
| cfg_target | input | 16 | Target ID |
| cfg_raddr | input | 32 | Starting remote address |
| cfg_sys_size | input | 4 | System-size code |
| cfg_irq | input | 1 | Request interrupt on the final descriptor |
| ent_valid | input | 1 | Entry valid |
| ent_ready | output | 1 | Entry accepted when high together with valid |
| ent_addr | input | 32 | Entry local address |
| ent_len | input | LEN_W | Entry length in bytes |
| ent_last | input | 1 | Last entry of the transfer |
| wr_en | output | 1 | Descriptor write strobe |
| wr_slot | output | $clog2(RING) | Ring slot being written |
| wr_w0 | output | 32 | Type / request / target word |
| wr_w1 | output | 32 | Count word |
| wr_w2 | output | 32 | Remote address word |
| wr_w3 | output | 32 | Local buffer address |
| done | output | 1 | Transfer finished |
| done_first | output | $clog2(RING) | Slot of the first descriptor |
| done_count | output | 16 | Descriptors written |
| done_err | output | 1 | Transfer aborted for an oversized entry |

## Verification
The hardest case to reach is an abort that comes after descriptors have already been written, at a moment when the write counter has gone round the ring and stepped over the link slot. The only evidence of the rollback is where the following transfer begins. The stimulus runs many random transfers back to back on an eight-slot ring, so the counter wraps many times. It mixes in oversized entries both in the middle and at the end of a transfer. The bench model tracks the same counter and checks the first slot of every transfer. Directed transfers land exactly on the byte ceiling and one byte over it.

// File: rtl/sgc_pkg.sv
package sgc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN, ST_FIN} sgc_state_t;

  localparam logic [2:0] DTYPE_DATA = 3'd1;

  function automatic logic [3:0] sgc_req_code(input logic to_dev, input logic [1:0] mode);
    if (!to_dev)          return 4'd0;
    else if (mode == 2'd0) return 4'd1;
    else if (mode == 2'd1) return 4'd2;
    else                   return 4'd3;
  endfunction
endpackage

// File: rtl/sgc_slot_alloc.sv
module sgc_slot_alloc #(
  parameter int RING = 8,
  localparam int SW = $clog2(RING)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc,
  input  logic          mark,
  input  logic          rollback,
  output logic [SW-1:0] slot
);
  logic [SW-1:0] cnt;
  logic [SW-1:0] saved;
  logic          skip;

  always_comb begin
    skip = (cnt == SW'(RING - 1));
    slot = skip ? '0 : cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      saved <= '0;
    end else begin
      if (mark) saved <= cnt;
      if (rollback)   cnt <= saved;
      else if (alloc) cnt <= cnt + (skip ? SW'(2) : SW'(1));
    end
  end

  // R3
  rollback_chk: assert property (@(posedge clk) disable iff (rst)
    (rollback && !mark) |=> (cnt == $past(saved)));

  // R5
  no_link_alloc_chk: assert property (@(posedge clk) disable iff (rst)
    alloc |-> (slot != SW'(RING - 1)));
endmodule

// File: rtl/sgc_desc_pack.sv
module sgc_desc_pack #(
  parameter int LEN_W = 26
) (
  input  logic [15:0]      tid,
  input  logic [3:0]       req,
  input  logic             iof,
  input  logic [3:0]       sys,
  input  logic [31:0]      raddr,
  input  logic [LEN_W-1:0] cnt,
  input  logic [31:0]      laddr,
  output logic [31:0]      w0,
  output logic [31:0]      w1,
  output logic [31:0]      w2,
  output logic [31:0]      w3
);
  import sgc_pkg::*;
  logic [25:0] cnt26;

  always_comb begin
    cnt26 = 26'(cnt);
    w0 = {DTYPE_DATA, 1'b0, iof, 4'b0, req, 3'b0, tid};
    w1 = {raddr[1:0], sys, cnt26};
    w2 = {2'b00, raddr[31:2]};
    w3 = laddr;
  end
endmodule

// File: rtl/sgc_coalescer.sv
module sgc_coalescer #(
  parameter int RING      = 8,
  parameter int LEN_W     = 26,
  parameter int MAX_BYTES = 4096,
  localparam int SW = $clog2(RING),
  localparam int NW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cfg_to_dev,
  input  logic [1:0]       cfg_wr_mode,
  input  logic [15:0]      cfg_target,
  input  logic [31:0]      cfg_raddr,
  input  logic [3:0]       cfg_sys_size,
  input  logic             cfg_irq,
  input  logic             ent_valid,
  output logic             ent_ready,
  input  logic [31:0]      ent_addr,
  input  logic [LEN_W-1:0] ent_len,
  input  logic             ent_last,
  output logic             wr_en,
  output logic [SW-1:0]    wr_slot,
  output logic [31:0]      wr_w0,
  output logic [31:0]      wr_w1,
  output logic [31:0]      wr_w2,
  output logic [31:0]      wr_w3,
  output logic             done,
  output logic [SW-1:0]    done_first,
  output logic [NW-1:0]    done_count,
  output logic             done_err
);
  import sgc_pkg::*;

  sgc_state_t state;

  logic [15:0]      c_tid;
  logic [3:0]       c_req;
  logic [3:0]       c_sys;
  logic             c_irq;
  logic [31:0]      raddr_run;
  logic [31:0]      next_loc;
  logic             open_v;
  logic [SW-1:0]    o_slot;
  logic [LEN_W-1:0] o_cnt;
  logic [31:0]      o_raddr;
  logic [31:0]      o_laddr;
  logic [SW-1:0]    first_slot;
  logic [NW-1:0]    ndesc;

  logic             acc_run, acc_drain, too_big, merge, alloc, mark, rollback;
  logic [LEN_W:0]   sum;
  logic [SW-1:0]    new_slot;
  logic [31:0]      pk_w0, pk_w1, pk_w2, pk_w3;
  logic             pk_iof;

  assign ent_ready = (state == ST_RUN) || (state == ST_DRAIN);

  always_comb begin
    acc_run   = ent_valid && (state == ST_RUN);
    acc_drain = ent_valid && (state == ST_DRAIN);
    too_big   = ent_len > LEN_W'(MAX_BYTES);
    sum       = {1'b0, o_cnt} + {1'b0, ent_len};
    merge     = open_v && (ent_addr == next_loc) && (sum <= (LEN_W+1)'(MAX_BYTES));
    alloc     = acc_run && !too_big && !merge;
    rollback  = acc_run && too_big;
    mark      = start && (state == ST_IDLE);
    pk_iof    = (state == ST_FIN) && c_irq;
  end

  sgc_slot_alloc #(.RING(RING)) alloc_i (
    .clk(clk), .rst(rst), .alloc(alloc), .mark(mark),
    .rollback(rollback), .slot(new_slot)
  );

  sgc_desc_pack #(.LEN_W(LEN_W)) pack_i (
    .tid(c_tid), .req(c_req), .iof(pk_iof), .sys(c_sys),
    .raddr(o_raddr), .cnt(o_cnt), .laddr(o_laddr),
    .w0(pk_w0), .w1(pk_w1), .w2(pk_w2), .w3(pk_w3)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      c_tid      <= '0;
      c_req      <= '0;
      c_sys      <= '0;
      c_irq      <= 1'b0;
      raddr_run  <= '0;
      next_loc   <= '0;
      open_v     <= 1'b0;
      o_slot     <= '0;
      o_cnt      <= '0;
      o_raddr    <= '0;
      o_laddr    <= '0;
      first_slot <= '0;
      ndesc      <= '0;
      wr_en      <= 1'b0;
      wr_slot    <= '0;
      wr_w0      <= '0;
      wr_w1      <= '0;
      wr_w2      <= '0;
      wr_w3      <= '0;
      done       <= 1'b0;
      done_first <= '0;
      done_count <= '0;
      done_err   <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      done  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            c_tid     <= cfg_target;
            c_req     <= sgc_req_code(cfg_to_dev, cfg_wr_mode);
            c_sys     <= cfg_sys_size;
            c_irq     <= cfg_irq;
            raddr_run <= cfg_raddr;
            open_v    <= 1'b0;
            ndesc     <= '0;
            state     <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (acc_run) begin
            if (too_big) begin
              open_v <= 1'b0;
              if (ent_last) begin
                done       <= 1'b1;
                done_err   <= 1'b1;
                done_count <= '0;
                done_first <= first_slot;
                state      <= ST_IDLE;
              end else begin
                state <= ST_DRAIN;
              end
            end else begin
              raddr_run <= raddr_run + 32'(ent_len);
              if (merge) begin
                o_cnt    <= sum[LEN_W-1:0];
                next_loc <= next_loc + 32'(ent_len);
              end else begin
                if (open_v) begin
                  wr_en   <= 1'b1;
                  wr_slot <= o_slot;
                  wr_w0   <= pk_w0;
                  wr_w1   <= pk_w1;
                  wr_w2   <= pk_w2;
                  wr_w3   <= pk_w3;
                  ndesc   <= ndesc + 1'b1;
                end else begin
                  first_slot <= new_slot;
                end
                open_v   <= 1'b1;
                o_slot   <= new_slot;
                o_cnt    <= ent_len;
                o_raddr  <= raddr_run;
                o_laddr  <= ent_addr;
                next_loc <= ent_addr + 32'(ent_len);
              end
              if (ent_last) state <= ST_FIN;
            end
          end
        end
        ST_DRAIN: begin
          if (acc_drain && ent_last) begin
            done       <= 1'b1;
            done_err   <= 1'b1;
            done_count <= '0;
            done_first <= first_slot;
            state      <= ST_IDLE;
          end
        end
        default: begin
          wr_en      <= 1'b1;
          wr_slot    <= o_slot;
          wr_w0      <= pk_w0;
          wr_w1      <= pk_w1;
          wr_w2      <= pk_w2;
          wr_w3      <= pk_w3;
          open_v     <= 1'b0;
          done       <= 1'b1;
          done_err   <= 1'b0;
          done_count <= ndesc + 1'b1;
          done_first <= first_slot;
          state      <= ST_IDLE;
        end
      endcase
    end
  end

  // R5
  no_link_slot_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_slot != SW'(RING - 1)));

  // R7
  count_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_w1[25:0] <= 26'(MAX_BYTES)));

  // R6
  data_type_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_w0[31:29] == 3'd1));

  // R10
  ready_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !ent_ready);

  // R3
  err_no_count_chk: assert property (@(posedge clk) disable iff (rst)
    (done && done_err) |-> (done_count == '0 && !wr_en));
endmodule

// File: tb/sgc_coalescer_tb_top.sv
module sgc_coalescer_tb_top;
  localparam int RING = 8;
  localparam int LEN_W = 26;
  localparam int MAXB = 4096;
  localparam int SW = $clog2(RING);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic start = 0, cfg_to_dev = 0, cfg_irq = 0;
  logic [1:0] cfg_wr_mode = 0;
  logic [15:0] cfg_target = 0;
  logic [31:0] cfg_raddr = 0;
  logic [3:0] cfg_sys_size = 0;
  logic ent_valid = 0, ent_last = 0;
  logic ent_ready;
  logic [31:0] ent_addr = 0;
  logic [LEN_W-1:0] ent_len = 0;
  logic wr_en, done, done_err;
  logic [SW-1:0] wr_slot, done_first;
  logic [31:0] wr_w0, wr_w1, wr_w2, wr_w3;
  logic [15:0] done_count;

  sgc_coalescer #(.RING(RING), .LEN_W(LEN_W), .MAX_BYTES(MAXB)) dut_i (
    .clk(clk), .rst(rst), .start(start), .cfg_to_dev(cfg_to_dev),
    .cfg_wr_mode(cfg_wr_mode), .cfg_target(cfg_target), .cfg_raddr(cfg_raddr),
    .cfg_sys_size(cfg_sys_size), .cfg_irq(cfg_irq), .ent_valid(ent_valid),
    .ent_ready(ent_ready), .ent_addr(ent_addr), .ent_len(ent_len),
    .ent_last(ent_last), .wr_en(wr_en), .wr_slot(wr_slot), .wr_w0(wr_w0),
    .wr_w1(wr_w1), .wr_w2(wr_w2), .wr_w3(wr_w3), .done(done),
    .done_first(done_first), .done_count(done_count), .done_err(done_err)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // stimulus and expected state
  int n_ent;
  logic [31:0] e_addr [0:63];
  logic [31:0] e_len  [0:63];
  int m_cnt = 0;
  int x_n, x_count, x_first;
  bit x_err;
  int x_slot [0:63];
  logic [31:0] x_w0 [0:63], x_w1 [0:63], x_w2 [0:63], x_w3 [0:63];

  // captured
  int g_n;
  int g_slot [0:63];
  logic [31:0] g_w0 [0:63], g_w1 [0:63], g_w2 [0:63], g_w3 [0:63];
  bit d_seen;
  int d_first, d_count;
  bit d_err;

  always @(negedge clk) begin
    if (!rst) begin
      if (wr_en && g_n < 64) begin
        g_slot[g_n] = int'(wr_slot);
        g_w0[g_n] = wr_w0; g_w1[g_n] = wr_w1; g_w2[g_n] = wr_w2; g_w3[g_n] = wr_w3;
        g_n = g_n + 1;
      end
      if (done) begin
        d_seen = 1; d_first = int'(done_first); d_count = int'(done_count); d_err = done_err;
      end
    end
  end

  task automatic chk(input bit ok, input string msg, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", msg, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_req(input logic to_dev, input logic [1:0] mode);
    if (!to_dev) return 4'd0;
    case (mode)
      2'd0: return 4'd1;
      2'd1: return 4'd2;
      default: return 4'd3;
    endcase
  endfunction

  task automatic push_exp(input int slot, input logic iof, input logic [31:0] cnt,
                          input logic [31:0] ra, input logic [31:0] la);
    x_slot[x_n] = slot;
    x_w0[x_n] = {3'd1, 1'b0, iof, 4'b0, exp_req(cfg_to_dev, cfg_wr_mode), 3'b0, cfg_target};
    x_w1[x_n] = {ra[1:0], cfg_sys_size, cnt[25:0]};
    x_w2[x_n] = {2'b00, ra[31:2]};
    x_w3[x_n] = la;
    x_n++;
  endtask

  task automatic model();
    bit open = 0;
    int saved = m_cnt;
    int oslot = 0, slot;
    logic [31:0] ocnt = 0, ora = 0, ola = 0, nl = 0, ra = cfg_raddr;
    x_n = 0; x_err = 0; x_first = 0;
    for (int i = 0; i < n_ent; i++) begin
      if (x_err) continue;
      if (e_len[i] > MAXB) begin
        x_err = 1; m_cnt = saved; open = 0;
        continue;
      end
      if (open && e_addr[i] == nl && ocnt + e_len[i] <= MAXB) begin
        ocnt += e_len[i]; nl += e_len[i];
      end else begin
        if (open) push_exp(oslot, 1'b0, ocnt, ora, ola);
        if (m_cnt == RING - 1) begin slot = 0; m_cnt = (m_cnt + 2) % RING; end
        else begin slot = m_cnt; m_cnt = (m_cnt + 1) % RING; end
        if (!open) x_first = slot;
        open = 1; oslot = slot; ocnt = e_len[i]; ora = ra; ola = e_addr[i];
        nl = e_addr[i] + e_len[i];
      end
      ra += e_len[i];
    end
    if (!x_err) push_exp(oslot, cfg_irq, ocnt, ora, ola);
    x_count = x_err ? 0 : x_n;
  endtask

  task automatic run_xfer();
    int k;
    model();
    g_n = 0; d_seen = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    for (int i = 0; i < n_ent; i++) begin
      ent_valid = 1; ent_addr = e_addr[i]; ent_len = e_len[i][LEN_W-1:0];
      ent_last = (i == n_ent - 1);
      while (!ent_ready) @(negedge clk);
      @(negedge clk);
    end
    ent_valid = 0; ent_last = 0;
    k = 0;
    while (!d_seen && k < 100) begin @(posedge clk); @(negedge clk); k++; end
    chk(d_seen, "R10 done pulse seen", 32'(d_seen), 1);
    // R2 / R1: descriptor count
    chk(g_n == x_n, "R2 descriptors written", g_n, x_n);
    for (int j = 0; j < x_n && j < g_n; j++) begin
      chk(g_slot[j] == x_slot[j], "R5 slot", g_slot[j], x_slot[j]);
      chk(g_w0[j] == x_w0[j], "R6 word0", g_w0[j], x_w0[j]);
      chk(g_w1[j] == x_w1[j], "R7 word1 count", g_w1[j], x_w1[j]);
      chk(g_w2[j] == x_w2[j], "R4 word2 remote addr", g_w2[j], x_w2[j]);
      chk(g_w3[j] == x_w3[j], "R9 word3 local addr", g_w3[j], x_w3[j]);
    end
    chk(d_err == x_err, "R3 done_err", 32'(d_err), 32'(x_err));
    chk(d_count == x_count, "R10 done_count", d_count, x_count);
    if (!x_err) chk(d_first == x_first, "R10 done_first", d_first, x_first);
  endtask

  task automatic set_cfg(input logic dir, input logic [1:0] mode, input logic irq);
    cfg_to_dev = dir; cfg_wr_mode = mode; cfg_irq = irq;
    cfg_target = 16'($urandom); cfg_raddr = $urandom; cfg_sys_size = 4'($urandom);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    chk(!wr_en, "R11 wr_en after reset", 32'(wr_en), 0);
    chk(!done, "R11 done after reset", 32'(done), 0);
    chk(!ent_ready, "R11 ready idle after reset", 32'(ent_ready), 0);

    // R1: exact ceiling merges into one descriptor
    set_cfg(1, 2'd0, 1);
    n_ent = 2; e_addr[0] = 32'h1000; e_len[0] = 2048; e_addr[1] = 32'h1800; e_len[1] = 2048;
    run_xfer();
    chk(g_n == 1, "R1 merge at ceiling", g_n, 1);
    chk(g_w1[0][25:0] == 26'd4096, "R1 merged count", g_w1[0], 4096);
    chk(g_slot[0] == 0, "R11 first slot zero", g_slot[0], 0);
    chk(g_w0[0][22:19] == 4'd1, "R8 mode0 code", 32'(g_w0[0][22:19]), 1);
    chk(g_w0[0][27] == 1'b1, "R6 irq on final", 32'(g_w0[0][27]), 1);

    // R2: one byte over the ceiling splits
    set_cfg(1, 2'd1, 1);
    n_ent = 2; e_addr[0] = 32'h2000; e_len[0] = 2048; e_addr[1] = 32'h2800; e_len[1] = 2049;
    run_xfer();
    chk(g_n == 2, "R2 split over ceiling", g_n, 2);
    chk(g_w0[0][27] == 1'b0, "R6 no irq on non-final", 32'(g_w0[0][27]), 0);
    chk(g_w0[0][22:19] == 4'd2, "R8 mode1 code", 32'(g_w0[0][22:19]), 2);

    // R2: gap splits
    set_cfg(1, 2'd3, 0);
    n_ent = 2; e_addr[0] = 32'h3000; e_len[0] = 100; e_addr[1] = 32'h3068; e_len[1] = 100;
    run_xfer();
    chk(g_n == 2, "R2 gap split", g_n, 2);
    chk(g_w0[1][27] == 1'b0, "R6 irq not requested", 32'(g_w0[1][27]), 0);
    chk(g_w0[1][22:19] == 4'd3, "R8 mode3 code", 32'(g_w0[1][22:19]), 3);

    // R8 read direction
    set_cfg(0, 2'd1, 1);
    n_ent = 1; e_addr[0] = 32'h4000; e_len[0] = 64;
    run_xfer();
    chk(g_w0[0][22:19] == 4'd0, "R8 read code", 32'(g_w0[0][22:19]), 0);

    // R3 error after descriptors written, then drained
    set_cfg(1, 2'd2, 1);
    n_ent = 4;
    e_addr[0] = 32'h5000; e_len[0] = 100; e_addr[1] = 32'h6000; e_len[1] = 100;
    e_addr[2] = 32'h7000; e_len[2] = MAXB + 1; e_addr[3] = 32'h8000; e_len[3] = 10;
    run_xfer();
    chk(g_n == 1, "R3 only closed desc written", g_n, 1);
    // R3 rollback: next transfer starts where the aborted one did
    set_cfg(1, 2'd0, 0);
    n_ent = 1; e_addr[0] = 32'h9000; e_len[0] = 8;
    run_xfer();
    // R3 error on the last single entry
    set_cfg(0, 2'd0, 1);
    n_ent = 1; e_addr[0] = 32'hA000; e_len[0] = MAXB + 100;
    run_xfer();

    // random transfers
    for (int t = 0; t < 60; t++) begin
      logic [31:0] a;
      set_cfg(1'($urandom), 2'($urandom), 1'($urandom));
      n_ent = 1 + ($urandom % 7);
      a = $urandom;
      for (int i = 0; i < n_ent; i++) begin
        if (i > 0 && ($urandom % 10) < 6) a = e_addr[i-1] + e_len[i-1];
        else a = $urandom;
        e_addr[i] = a;
        e_len[i] = (($urandom % 40) == 0) ? MAXB + 1 + ($urandom % 50) : 1 + ($urandom % 1500);
      end
      run_xfer();
    end

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule